// File: doc/BRIEF.md
# Parallel EEPROM Write-Cycle Controller

This block models the control side of a byte-wide nonvolatile memory of 2,048 bytes. The memory is driven by three active-low strobes: chip select, output enable and write enable. A system clock samples the strobes, so they may change at any time. Reads behave like a static RAM.

A write is a low pulse on write enable or chip select while output enable is high. A pulse of this kind latches an address and a data byte. A self-timed internal write follows. It first erases the location to 0xFF and then programs the new byte. While this busy period lasts, reads return polling status instead of stored data, and an open-drain busy indication is pulled low.

Writes are refused when the strobes are in an inhibiting combination, when the supply-good input is low, and while a power-up lockout timer runs. A separate 32-byte identification store is reachable through the top 32 addresses while a high-voltage flag on address line 9 is asserted.

Top module: `eewc_top`

## Requirements
- R1: The main store holds 2,048 bytes selected by an 11-bit address, and every byte reads 0xFF after reset. A byte written at an address reads back unchanged at that address.
- R2: With chip select and output enable low and write enable high, `data_oe_o` is 1 and `data_o` carries the addressed byte no later than 4 clock cycles after the strobes settle. Whenever chip select or output enable is high, `data_oe_o` is 0 within 4 cycles.
- R3: A write is armed when the later of chip select and write enable falls while output enable is high. The address is captured at that moment. The write begins when the first of the two rises while output enable is still high, and the data byte is captured at that rise. Either strobe may be the one that controls the timing.
- R4: During a busy period a read returns the inverse of bit 7 of the byte being written on `data_o[7]`, with bits 6:0 at 0. Once the busy period ends, the true stored byte appears.
- R5: `busy_pull_o` is 1 (pin pulled low) for exactly `WRITE_CYCLES` clock cycles for each accepted write, and is 0 otherwise. Within that period the location is erased to 0xFF before the new byte is programmed.
- R6: Strobe pulses that start or end during a busy period start no write and change no stored byte.
- R7: No write starts from a write-enable pulse while output enable is low, nor from any pulse while chip select is held high.
- R8: After reset, and after each rise of `supply_ok_i`, writes are refused until `supply_ok_i` has stayed high for `POWERUP_CYCLES` cycles.
- R9: While `supply_ok_i` is 0, no write starts.
- R10: With `hv_a9_i` at 1, addresses 0x7E0 to 0x7FF read and write a separate 32-byte identification store, which also resets to 0xFF. With `hv_a9_i` at 0, the same addresses reach the main store, and each store leaves the other untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok_i | input | 1 | Supply-good indication; low inhibits writes |
| ce_n_i | input | 1 | Chip select, active low, asynchronous |
| oe_n_i | input | 1 | Output enable, active low, asynchronous |
| we_n_i | input | 1 | Write enable, active low, asynchronous |
| hv_a9_i | input | 1 | High-voltage flag on address line 9; selects the identification store |
| addr_i | input | 11 | Byte address |
| data_i | input | 8 | Write data |
| data_o | output | 8 | Read data or polling status |
| data_oe_o | output | 1 | Output-drive enable for the data pins |
| busy_pull_o | output | 1 | Open-drain pull-down control for the ready/busy pin; 1 while a write runs |

## Verification
The bench builds the block with `WRITE_CYCLES` = 40 and `POWERUP_CYCLES` = 60, in place of the millisecond defaults. With these values, dozens of complete erase-and-program cycles fit in a short run. The exact busy length can be counted cycle by cycle. A write attempted inside the lockout window can be compared with one attempted just after it expires. The short busy window still has room for polling reads and a second, ignored write pulse before the first write finishes.

// File: rtl/eewc_pkg.sv
package eewc_pkg;

    localparam int ADDR_W = 11;
    localparam int DATA_W = 8;
    localparam int ID_AW  = 5;
    localparam logic [DATA_W-1:0] ERASED = '1;

    typedef enum logic [1:0] {
        WC_IDLE,
        WC_CLEAR,
        WC_PROGRAM
    } wc_state_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
    } strobe_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              id_sel;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    // Identification store is hit by the top 2**ID_AW addresses with the flag raised
    function automatic logic id_hit(input logic hv, input logic [ADDR_W-1:0] a);
        return hv && (a[ADDR_W-1:ID_AW] == '1);
    endfunction

endpackage

// File: rtl/eewc_strobe_sync.sv
module eewc_strobe_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] lvl_o
);

    generate
        for (genvar g = 0; g < WIDTH; g++) begin : g_bit
            logic [STAGES-1:0] sh_q;
            always_ff @(posedge clk) begin
                if (rst) sh_q <= '1;
                else     sh_q <= {sh_q[STAGES-2:0], raw_i[g]};
            end
            assign lvl_o[g] = sh_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/eewc_write_ctrl.sv
module eewc_write_ctrl
    import eewc_pkg::*;
#(
    parameter int WRITE_CYCLES   = 375000,
    parameter int POWERUP_CYCLES = 625000
) (
    input  logic              clk,
    input  logic              rst,
    input  strobe_t           stb_i,
    input  logic              supply_ok_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              hv_i,
    output logic              busy_o,
    output logic              lock_done_o,
    output logic              mem_we_o,
    output wr_req_t           mem_req_o,
    output logic [DATA_W-1:0] mem_wdata_o
);

    localparam int TW = $clog2(WRITE_CYCLES + 1);
    localparam int PW = $clog2(POWERUP_CYCLES + 2);
    localparam logic [TW-1:0] LAST_T   = TW'(WRITE_CYCLES - 1);
    localparam logic [TW-1:0] CLEAR_T  = TW'(WRITE_CYCLES / 2 - 1);
    localparam logic [PW-1:0] LOCK_END = PW'(POWERUP_CYCLES);

    wc_state_e     state_q;
    logic [TW-1:0] tmr_q;
    logic [PW-1:0] pwr_q;
    wr_req_t       req_q;
    logic          w_act, w_act_q, armed_q;
    logic          arm_edge, end_edge, accept;
    logic          idle;

    assign idle     = (state_q == WC_IDLE);
    assign w_act    = !stb_i.ce_n && !stb_i.we_n && stb_i.oe_n;
    assign arm_edge = w_act && !w_act_q;
    assign end_edge = !w_act && w_act_q && stb_i.oe_n;
    assign accept   = end_edge && armed_q && idle && supply_ok_i && lock_done_o;

    // Power-up lockout: restarts whenever the supply drops
    always_ff @(posedge clk) begin
        if (rst || !supply_ok_i) pwr_q <= '0;
        else if (pwr_q != LOCK_END) pwr_q <= pwr_q + 1'b1;
    end
    assign lock_done_o = (pwr_q == LOCK_END);

    // Strobe edge tracking and request capture
    always_ff @(posedge clk) begin
        if (rst) begin
            w_act_q <= 1'b0;
            armed_q <= 1'b0;
            req_q   <= '0;
        end else begin
            w_act_q <= w_act;
            if (arm_edge && idle) begin
                armed_q      <= 1'b1;
                req_q.addr   <= addr_i;
                req_q.id_sel <= id_hit(hv_i, addr_i);
            end else if (!w_act && w_act_q) begin
                armed_q <= 1'b0;
            end
            if (accept) req_q.data <= data_i;
        end
    end

    // Self-timed erase then program sequence
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WC_IDLE;
            tmr_q   <= '0;
        end else begin
            unique case (state_q)
                WC_IDLE: begin
                    tmr_q <= '0;
                    if (accept) state_q <= WC_CLEAR;
                end
                WC_CLEAR: begin
                    tmr_q <= tmr_q + 1'b1;
                    if (tmr_q == CLEAR_T) state_q <= WC_PROGRAM;
                end
                WC_PROGRAM: begin
                    tmr_q <= tmr_q + 1'b1;
                    if (tmr_q == LAST_T) state_q <= WC_IDLE;
                end
                default: state_q <= WC_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_we_o    = 1'b0;
        mem_wdata_o = req_q.data;
        if (state_q == WC_CLEAR && tmr_q == CLEAR_T) begin
            mem_we_o    = 1'b1;
            mem_wdata_o = ERASED;
        end else if (state_q == WC_PROGRAM && tmr_q == LAST_T) begin
            mem_we_o    = 1'b1;
        end
    end

    assign busy_o    = !idle;
    assign mem_req_o = req_q;

endmodule

// File: rtl/eewc_store.sv
module eewc_store
    import eewc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  wr_req_t           wreq_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic              rd_id_i,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int DEPTH    = 1 << ADDR_W;
    localparam int ID_DEPTH = 1 << ID_AW;

    logic [DATA_W-1:0] main_q [DEPTH];
    logic [DATA_W-1:0] id_q   [ID_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)    main_q[i] <= ERASED;
            for (int j = 0; j < ID_DEPTH; j++) id_q[j]   <= ERASED;
        end else if (we_i) begin
            if (wreq_i.id_sel) id_q[wreq_i.addr[ID_AW-1:0]] <= wdata_i;
            else               main_q[wreq_i.addr]         <= wdata_i;
        end
    end

    assign rd_data_o = rd_id_i ? id_q[rd_addr_i[ID_AW-1:0]] : main_q[rd_addr_i];

endmodule

// File: rtl/eewc_top.sv
module eewc_top
    import eewc_pkg::*;
#(
    parameter int WRITE_CYCLES   = 375000,
    parameter int POWERUP_CYCLES = 625000,
    parameter int SYNC_STAGES    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              supply_ok_i,
    input  logic              ce_n_i,
    input  logic              oe_n_i,
    input  logic              we_n_i,
    input  logic              hv_a9_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o,
    output logic              busy_pull_o
);

    strobe_t           stb_w;
    logic [2:0]        stb_raw;
    logic              busy_w, lock_done_w, mem_we_w, rd_en_w;
    wr_req_t           req_w;
    logic [DATA_W-1:0] wdata_w, rd_data_w;
    logic              poll_w;

    assign stb_raw = {ce_n_i, oe_n_i, we_n_i};

    eewc_strobe_sync #(
        .WIDTH (3),
        .STAGES(SYNC_STAGES)
    ) sync_i (
        .clk  (clk),
        .rst  (rst),
        .raw_i(stb_raw),
        .lvl_o(stb_w)
    );

    eewc_write_ctrl #(
        .WRITE_CYCLES  (WRITE_CYCLES),
        .POWERUP_CYCLES(POWERUP_CYCLES)
    ) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .stb_i      (stb_w),
        .supply_ok_i(supply_ok_i),
        .addr_i     (addr_i),
        .data_i     (data_i),
        .hv_i       (hv_a9_i),
        .busy_o     (busy_w),
        .lock_done_o(lock_done_w),
        .mem_we_o   (mem_we_w),
        .mem_req_o  (req_w),
        .mem_wdata_o(wdata_w)
    );

    eewc_store store_i (
        .clk      (clk),
        .rst      (rst),
        .we_i     (mem_we_w),
        .wreq_i   (req_w),
        .wdata_i  (wdata_w),
        .rd_addr_i(addr_i),
        .rd_id_i  (id_hit(hv_a9_i, addr_i)),
        .rd_data_o(rd_data_w)
    );

    assign poll_w  = req_w.data[DATA_W-1];
    assign rd_en_w = !stb_w.ce_n && !stb_w.oe_n && stb_w.we_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_oe_o <= 1'b0;
            data_o    <= '0;
        end else begin
            data_oe_o <= rd_en_w;
            data_o    <= busy_w ? {~poll_w, {(DATA_W-1){1'b0}}} : rd_data_w;
        end
    end

    assign busy_pull_o = busy_w;

endmodule

// File: rtl/eewc_checker.sv
module eewc_checker
    import eewc_pkg::*;
#(
    parameter int WRITE_CYCLES = 375000
) (
    input logic              clk,
    input logic              rst,
    input logic              ce_n_i,
    input logic              supply_ok_i,
    input logic              busy,
    input logic              lock_done,
    input logic              data_oe_o,
    input logic [DATA_W-1:0] data_o,
    input logic              poll_ref
);

    logic [2:0]  since_q;
    logic [31:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= '0;
            run_q   <= '0;
        end else begin
            if (since_q != 3'd4) since_q <= since_q + 1'b1;
            run_q <= busy ? run_q + 1 : 32'd0;
        end
    end

    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (since_q == 3'd4 && ce_n_i && $past(ce_n_i) && $past(ce_n_i, 2) && $past(ce_n_i, 3)) |-> !data_oe_o); // R2

    AST_POLL_INVERT: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (data_o[DATA_W-1] == ~poll_ref && data_o[DATA_W-2:0] == '0)); // R4

    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_q < 32'(WRITE_CYCLES))); // R5

    AST_BUSY_FULL: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_q == 32'(WRITE_CYCLES))); // R5

    AST_LOCKOUT_GATE: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(lock_done)); // R8

    AST_SUPPLY_GATE: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(supply_ok_i)); // R9

endmodule

bind eewc_top eewc_checker #(.WRITE_CYCLES(WRITE_CYCLES)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .ce_n_i     (ce_n_i),
    .supply_ok_i(supply_ok_i),
    .busy       (busy_w),
    .lock_done  (lock_done_w),
    .data_oe_o  (data_oe_o),
    .data_o     (data_o),
    .poll_ref   (poll_w)
);

// File: tb/eewc_top_tb_top.sv
module eewc_top_tb_top;

    localparam int WC = 40;
    localparam int PC = 60;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        supply_ok = 1'b1;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, hv = 1'b0;
    logic [10:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        doe, busy;

    int checks = 0, errors = 0;
    int run = 0, last_run = 0, starts = 0;
    logic [7:0] ref_main [2048];
    logic [7:0] ref_id   [32];

    always #4 clk = ~clk;

    eewc_top #(.WRITE_CYCLES(WC), .POWERUP_CYCLES(PC)) dut_i (
        .clk(clk), .rst(rst), .supply_ok_i(supply_ok),
        .ce_n_i(ce_n), .oe_n_i(oe_n), .we_n_i(we_n), .hv_a9_i(hv),
        .addr_i(addr), .data_i(din),
        .data_o(dout), .data_oe_o(doe), .busy_pull_o(busy)
    );

    // Busy-run measurement
    always @(negedge clk) begin
        if (busy) run = run + 1;
        else if (run != 0) begin
            last_run = run;
            starts   = starts + 1;
            run      = 0;
        end
    end

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors = errors + 1;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_sim();
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic tb_id(input logic h, input logic [10:0] a);
        return h && (a[10:5] == 6'h3F);
    endfunction

    function automatic logic [7:0] ref_read(input logic [10:0] a, input logic h);
        return tb_id(h, a) ? ref_id[a[4:0]] : ref_main[a];
    endfunction

    task automatic ref_write(input logic [10:0] a, input logic h, input logic [7:0] d);
        if (tb_id(h, a)) ref_id[a[4:0]] = d;
        else             ref_main[a]    = d;
    endtask

    // Strobe pulse: ce_ctrl selects which strobe falls last and rises first
    task automatic wr(input logic [10:0] a, input logic [7:0] d, input logic h, input logic ce_ctrl);
        @(negedge clk);
        addr = a; din = d; hv = h; oe_n = 1'b1;
        if (ce_ctrl) we_n = 1'b0; else ce_n = 1'b0;
        repeat (4) @(negedge clk);
        if (ce_ctrl) ce_n = 1'b0; else we_n = 1'b0;
        repeat (6) @(negedge clk);
        if (ce_ctrl) ce_n = 1'b1; else we_n = 1'b1;
        repeat (4) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic rd(input logic [10:0] a, input logic h, output logic [7:0] d, output logic oe);
        @(negedge clk);
        addr = a; hv = h; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
        repeat (6) @(negedge clk);
        d = dout; oe = doe;
        ce_n = 1'b1; oe_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        logic [7:0] d, dw;
        logic oe;
        logic [10:0] a;
        logic h;
        int s0;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 2048; i++) ref_main[i] = 8'hFF;
        for (int i = 0; i < 32; i++)   ref_id[i]   = 8'hFF;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R2 reset data_oe_o", {31'b0, doe}, 0);
        chk("R5 reset busy_pull_o", {31'b0, busy}, 0);

        // R8: write inside the power-up lockout is refused
        wr(11'h010, 8'h5A, 1'b0, 1'b0);
        repeat (10) @(negedge clk);
        chk("R8 no start during lockout", starts, 0);
        repeat (60) @(negedge clk);
        rd(11'h010, 1'b0, d, oe);
        chk("R1 erased after reset", {24'b0, d}, 32'hFF);
        chk("R2 output enabled on read", {31'b0, oe}, 1);
        chk("R2 deselected output off", {31'b0, doe}, 0);

        // R3/R5: WE-controlled write, exact busy length
        wr(11'h123, 8'hA5, 1'b0, 1'b0);
        ref_write(11'h123, 1'b0, 8'hA5);
        wait_idle();
        chk("R5 busy length", last_run, WC);
        chk("R5 single start", starts, 1);
        rd(11'h123, 1'b0, d, oe);
        chk("R3 WE-controlled write", {24'b0, d}, 32'hA5);

        // R3: CE-controlled write
        wr(11'h7FF, 8'h3C, 1'b0, 1'b1);
        ref_write(11'h7FF, 1'b0, 8'h3C);
        wait_idle();
        rd(11'h7FF, 1'b0, d, oe);
        chk("R3 CE-controlled write", {24'b0, d}, 32'h3C);

        // R4: polling read during busy, true data afterwards
        wr(11'h200, 8'h81, 1'b0, 1'b0);
        ref_write(11'h200, 1'b0, 8'h81);
        addr = 11'h200; hv = 1'b0; ce_n = 1'b0; oe_n = 1'b0;
        repeat (6) @(negedge clk);
        chk("R4 busy during poll", {31'b0, busy}, 1);
        chk("R4 poll value bit7=0", {24'b0, dout}, 32'h00);
        chk("R2 output enabled during poll", {31'b0, doe}, 1);
        wait_idle();
        repeat (3) @(negedge clk);
        chk("R4 true data after busy", {24'b0, dout}, 32'h81);
        ce_n = 1'b1; oe_n = 1'b1;
        repeat (6) @(negedge clk);
        wr(11'h201, 8'h7E, 1'b0, 1'b1);
        ref_write(11'h201, 1'b0, 8'h7E);
        addr = 11'h201; ce_n = 1'b0; oe_n = 1'b0;
        repeat (6) @(negedge clk);
        chk("R4 poll value bit7=1", {24'b0, dout}, 32'h80);
        ce_n = 1'b1; oe_n = 1'b1;
        wait_idle();

        // R6: write pulse during busy ignored
        s0 = starts;
        wr(11'h300, 8'h11, 1'b0, 1'b0);
        ref_write(11'h300, 1'b0, 8'h11);
        wr(11'h301, 8'h22, 1'b0, 1'b0);
        wait_idle();
        repeat (10) @(negedge clk);
        chk("R6 one start only", starts - s0, 1);
        rd(11'h301, 1'b0, d, oe);
        chk("R6 busy-time pulse no effect", {24'b0, d}, 32'hFF);
        rd(11'h300, 1'b0, d, oe);
        chk("R6 first write intact", {24'b0, d}, 32'h11);

        // R7: OE low during WE pulse
        s0 = starts;
        @(negedge clk);
        addr = 11'h055; din = 8'h99; oe_n = 1'b0; ce_n = 1'b0;
        repeat (4) @(negedge clk);
        we_n = 1'b0; repeat (6) @(negedge clk);
        we_n = 1'b1; repeat (4) @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
        // R7: CE high during WE pulse
        repeat (4) @(negedge clk);
        we_n = 1'b0; repeat (6) @(negedge clk);
        we_n = 1'b1; repeat (10) @(negedge clk);
        chk("R7 inhibited pulses start nothing", starts - s0, 0);
        rd(11'h055, 1'b0, d, oe);
        chk("R7 location untouched", {24'b0, d}, 32'hFF);

        // R9/R8: supply loss and restart lockout
        s0 = starts;
        supply_ok = 1'b0;
        wr(11'h066, 8'h44, 1'b0, 1'b0);
        repeat (10) @(negedge clk);
        chk("R9 no start with supply low", starts - s0, 0);
        supply_ok = 1'b1;
        wr(11'h066, 8'h45, 1'b0, 1'b1);
        repeat (10) @(negedge clk);
        chk("R8 no start inside restarted lockout", starts - s0, 0);
        repeat (60) @(negedge clk);
        wr(11'h066, 8'h46, 1'b0, 1'b0);
        ref_write(11'h066, 1'b0, 8'h46);
        wait_idle();
        chk("R8 start after lockout", starts - s0, 1);
        rd(11'h066, 1'b0, d, oe);
        chk("R8 write after lockout", {24'b0, d}, 32'h46);

        // R10: identification store
        rd(11'h7E5, 1'b1, d, oe);
        chk("R10 id store erased", {24'b0, d}, 32'hFF);
        wr(11'h7E5, 8'hC3, 1'b1, 1'b0);
        ref_write(11'h7E5, 1'b1, 8'hC3);
        wait_idle();
        rd(11'h7E5, 1'b1, d, oe);
        chk("R10 id store write", {24'b0, d}, 32'hC3);
        rd(11'h7E5, 1'b0, d, oe);
        chk("R10 main store untouched", {24'b0, d}, 32'hFF);
        rd(11'h7FF, 1'b1, d, oe);
        chk("R10 id top entry separate", {24'b0, d}, 32'hFF);

        // R1/R3/R10: constrained random writes and readbacks
        for (int k = 0; k < 24; k++) begin
            h  = ($urandom % 4) == 0;
            a  = h ? (11'h7E0 | 11'($urandom % 32)) : 11'($urandom % 2048);
            dw = 8'($urandom);
            wr(a, dw, h, 1'($urandom % 2));
            ref_write(a, h, dw);
            wait_idle();
            rd(a, h, d, oe);
            chk("R1 random readback", {24'b0, d}, {24'b0, ref_read(a, h)});
            a = 11'($urandom % 2048);
            rd(a, 1'b0, d, oe);
            chk("R1 random main read", {24'b0, d}, {24'b0, ref_read(a, 1'b0)});
        end

        finish_sim();
    end

endmodule